// File: doc/BRIEF.md
# Ready-Time Sorted Read Response Queue

This block sits between a memory scheduler and the read response path. Each read that has been sent to the memory is placed here along with its identifier, its address and the cycle at which its data becomes available. The block keeps its entries ordered by that due cycle, so the earliest completion is always at the head. The head is offered on a valid/ready response port once a free-running cycle counter has reached its due cycle.

The block also carries the bookkeeping that the read front end needs around the queue. It reports its occupancy and raises a full flag when its own entries plus the front end's pending reads reach the configured read buffer size. It remembers that a read was turned away and pulses a retry when a slot frees. It signals that the controller has gone idle when a drain was asked for and the last response leaves.

Top module: `rtq_queue`

## Requirements
- R1: An inserted entry is placed directly ahead of the first stored entry whose due cycle is strictly later than its own, or at the tail if none is later, so entries with equal due cycles leave in arrival order.
- R2: `rsp_valid` is high exactly when the queue is not empty and the head's due cycle has been reached. This is judged wrap-aware as the sign bit of the TW-bit difference `now - due` being 0. `rsp_id` and `rsp_addr` carry the head's fields, and no other entry is ever offered.
- R3: A cycle with `rsp_valid` and `rsp_ready` high removes the head. An insert in the same cycle is also taken, with no entry lost or duplicated, and `count` changes by at most one per cycle.
- R4: An insert while `count` equals DEPTH is ignored unless a response leaves in the same cycle. An ignored insert leaves `count` and the queue contents unchanged.
- R5: After reset `count` is 0 and `rsp_valid`, `retry_pulse` and `drained` are low. `count` always equals the number of stored entries and never exceeds DEPTH.
- R6: `rd_full` is high exactly when `pend_cnt + count` is at least RD_BUF.
- R7: A cycle with `rd_refused` high sets a sticky retry flag. In the cycle after a response leaves while the flag was set, `retry_pulse` is high for one cycle and the flag is cleared. A refusal in that same cycle sets the flag again.
- R8: `drained` is high for one cycle after a response leaves that empties the queue with no insert in that cycle, while `pend_cnt` is 0 and `wr_empty` and `drain_req` are high.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the next cycle still offers the same head with `rsp_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now | input | TW | Free-running cycle counter |
| ins_valid | input | 1 | Insert request |
| ins_id | input | IW | Identifier of the inserted read |
| ins_addr | input | AW | Address of the inserted read |
| ins_due | input | TW | Due cycle of the inserted read, not earlier than `now` |
| rsp_valid | output | 1 | Head is due |
| rsp_ready | input | 1 | Requester accepts the head |
| rsp_id | output | IW | Head identifier |
| rsp_addr | output | AW | Head address |
| count | output | clog2(DEPTH+1) | Stored entries |
| pend_cnt | input | clog2(RD_BUF+1) | Entries in the pending-read queue |
| rd_full | output | 1 | Combined read capacity reached |
| rd_refused | input | 1 | Front end turned a read away this cycle |
| retry_pulse | output | 1 | One-cycle retry to the requester |
| drain_req | input | 1 | A drain has been requested |
| wr_empty | input | 1 | Write queue is empty |
| drained | output | 1 | One-cycle idle indication |

## Verification
The bench builds the block with DEPTH=4, TW=8, IW=4, AW=8 and RD_BUF=6. The small depth makes the full-queue cases, inserts at every position and simultaneous insert and removal happen often. The 8-bit counter wraps many times over the run, so the wrap-aware due test and sort are exercised across the wrap. A directed tie pattern and an overfull insert open the run. They are followed by a long pseudo-random sweep with due delays of 0 to 5 cycles, compared each cycle against an arithmetic model of the sorted list, the retry flag and the drain condition.

// File: rtl/rtq_pkg.sv
package rtq_pkg;
  // width of a counter that must hold values 0..v
  function automatic int unsigned cnt_w(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/rtq_locate.sv
module rtq_locate #(
  parameter int DEPTH = 8,
  parameter int TW    = 16,
  parameter int CW    = 4
) (
  input  logic [TW-1:0] slot_due [DEPTH],
  input  logic [DEPTH-1:0] slot_vld,
  input  logic [TW-1:0] new_due,
  output logic [CW-1:0] pos
);
  logic [DEPTH-1:0] not_later;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [TW-1:0] diff;
    assign diff         = slot_due[i] - new_due;
    // slot is not later when diff <= 0 in wrap-aware signed sense
    assign not_later[i] = slot_vld[i] & (diff[TW-1] | (diff == '0));
  end

  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++) pos = pos + CW'(not_later[i]);
  end
endmodule

// File: rtl/rtq_store.sv
module rtq_store #(
  parameter int DEPTH = 8,
  parameter int EW    = 32,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins,
  input  logic          pop,
  input  logic [CW-1:0] pos,
  input  logic [EW-1:0] new_ent,
  output logic [EW-1:0] ent_q [DEPTH],
  output logic [CW-1:0] count_q
);
  logic [EW-1:0] ent_n [DEPTH];
  logic [CW-1:0] count_n;
  logic [CW-1:0] slot_p;
  logic          upd;

  assign slot_p  = (pop && pos != '0) ? pos - CW'(1) : pos;
  assign upd     = ins | pop;
  assign count_n = count_q + CW'(ins) - CW'(pop);

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    localparam int UP = (j + 1 < DEPTH) ? j + 1 : j;
    localparam int DN = (j > 0) ? j - 1 : 0;
    logic [EW-1:0] base_here, base_prev;
    assign base_here = pop ? ent_q[UP] : ent_q[j];
    assign base_prev = pop ? ent_q[j]  : ent_q[DN];
    always_comb begin
      if (!ins || CW'(j) < slot_p) ent_n[j] = base_here;
      else if (CW'(j) == slot_p)   ent_n[j] = new_ent;
      else                         ent_n[j] = base_prev;
    end
    always_ff @(posedge clk) begin
      if (upd) ent_q[j] <= ent_n[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (upd) count_q <= count_n;
  end
endmodule

// File: rtl/rtq_notify.sv
module rtq_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic pop,
  input  logic refused,
  input  logic last_out,
  input  logic idle_ok,
  output logic retry_q,
  output logic drained_q
);
  logic flag_q, flag_n, retry_n, drained_n;

  always_comb begin
    flag_n    = refused | (flag_q & ~pop);
    retry_n   = flag_q & pop;
    drained_n = last_out & idle_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      retry_q   <= 1'b0;
      drained_q <= 1'b0;
    end else begin
      flag_q    <= flag_n;
      retry_q   <= retry_n;
      drained_q <= drained_n;
    end
  end
endmodule

// File: rtl/rtq_queue.sv
module rtq_queue #(
  parameter int DEPTH  = 8,
  parameter int IW     = 6,
  parameter int AW     = 32,
  parameter int TW     = 16,
  parameter int RD_BUF = 12,
  parameter int CW     = rtq_pkg::cnt_w(DEPTH),
  parameter int PW     = rtq_pkg::cnt_w(RD_BUF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now,
  input  logic          ins_valid,
  input  logic [IW-1:0] ins_id,
  input  logic [AW-1:0] ins_addr,
  input  logic [TW-1:0] ins_due,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [IW-1:0] rsp_id,
  output logic [AW-1:0] rsp_addr,
  output logic [CW-1:0] count,
  input  logic [PW-1:0] pend_cnt,
  output logic          rd_full,
  input  logic          rd_refused,
  output logic          retry_pulse,
  input  logic          drain_req,
  input  logic          wr_empty,
  output logic          drained
);
  localparam int EW = IW + AW + TW;
  localparam int SW = (PW > CW ? PW : CW) + 1;

  logic [EW-1:0] ent_q [DEPTH];
  logic [TW-1:0] slot_due [DEPTH];
  logic [DEPTH-1:0] slot_vld;
  logic [CW-1:0] pos, count_q;
  logic [TW-1:0] head_due, head_lag;
  logic          pop, ins_acc, last_out, idle_ok;

  for (genvar i = 0; i < DEPTH; i++) begin : g_view
    assign slot_due[i] = ent_q[i][TW-1:0];
    assign slot_vld[i] = (CW'(i) < count_q);
  end

  assign head_due  = slot_due[0];
  assign head_lag  = now - head_due;
  assign rsp_valid = (count_q != '0) && !head_lag[TW-1];
  assign rsp_id    = ent_q[0][EW-1 -: IW];
  assign rsp_addr  = ent_q[0][TW +: AW];
  assign count     = count_q;

  assign pop      = rsp_valid & rsp_ready;
  assign ins_acc  = ins_valid & ((count_q < CW'(DEPTH)) | pop);
  assign last_out = pop & (count_q == CW'(1)) & ~ins_acc;
  assign idle_ok  = (pend_cnt == '0) & wr_empty & drain_req;
  assign rd_full  = (SW'(pend_cnt) + SW'(count_q)) >= SW'(RD_BUF);

  rtq_locate #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) i_locate (
    .slot_due(slot_due), .slot_vld(slot_vld), .new_due(ins_due), .pos(pos)
  );

  rtq_store #(.DEPTH(DEPTH), .EW(EW), .CW(CW)) i_store (
    .clk(clk), .rst_n(rst_n), .ins(ins_acc), .pop(pop), .pos(pos),
    .new_ent({ins_id, ins_addr, ins_due}), .ent_q(ent_q), .count_q(count_q)
  );

  rtq_notify i_notify (
    .clk(clk), .rst_n(rst_n), .pop(pop), .refused(rd_refused),
    .last_out(last_out), .idle_ok(idle_ok),
    .retry_q(retry_pulse), .drained_q(drained)
  );
endmodule

// File: rtl/rtq_queue_chk.sv
module rtq_queue_chk #(
  parameter int DEPTH = 8,
  parameter int IW    = 6,
  parameter int AW    = 32,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [IW-1:0] rsp_id,
  input logic [AW-1:0] rsp_addr,
  input logic [CW-1:0] count,
  input logic          retry_pulse,
  input logic          drained
);
  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R2
  valid_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> count != '0);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= $past(count) + CW'(1)) && (count + CW'(1) >= $past(count)));
  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) && $stable(rsp_addr)));
  // R7
  retry_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |-> $past(rsp_valid && rsp_ready));
  // R8
  drained_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> (count == '0) && $past(rsp_valid && rsp_ready));
endmodule

bind rtq_queue rtq_queue_chk #(.DEPTH(DEPTH), .IW(IW), .AW(AW), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_id(rsp_id), .rsp_addr(rsp_addr), .count(count),
  .retry_pulse(retry_pulse), .drained(drained)
);

// File: tb/test_rtq_queue.sv
`timescale 1ns/1ps
module test_rtq_queue;
  localparam int DEPTH = 4, IW = 4, AW = 8, TW = 8, RD_BUF = 6;
  localparam int CW = 3, PW = 3;

  logic clk, rst_n;
  logic [TW-1:0] now;
  logic ins_valid, rsp_ready, rd_refused, drain_req, wr_empty;
  logic [IW-1:0] ins_id;
  logic [AW-1:0] ins_addr;
  logic [TW-1:0] ins_due;
  logic [PW-1:0] pend_cnt;
  logic rsp_valid, rd_full, retry_pulse, drained;
  logic [IW-1:0] rsp_id;
  logic [AW-1:0] rsp_addr;
  logic [CW-1:0] count;

  int total = 0, bad = 0;
  bit finished = 0;

  int m_n;
  int m_id [DEPTH+1];
  int m_ad [DEPTH+1];
  logic [TW-1:0] m_rt [DEPTH+1];
  bit m_flag, e_retry, e_drained;
  int unsigned lcg = 32'h1234_5678;

  rtq_queue #(.DEPTH(DEPTH), .IW(IW), .AW(AW), .TW(TW), .RD_BUF(RD_BUF)) i_rtq_queue (
    .clk(clk), .rst_n(rst_n), .now(now), .ins_valid(ins_valid), .ins_id(ins_id),
    .ins_addr(ins_addr), .ins_due(ins_due), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_addr(rsp_addr), .count(count),
    .pend_cnt(pend_cnt), .rd_full(rd_full), .rd_refused(rd_refused),
    .retry_pulse(retry_pulse), .drain_req(drain_req), .wr_empty(wr_empty),
    .drained(drained)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at now=%0d", tag, act, exp, now);
    end
  endtask

  function automatic int rnd(input int m);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) % m);
  endfunction

  function automatic bit later(input logic [TW-1:0] a, input logic [TW-1:0] b);
    logic [TW-1:0] d;
    d = a - b;
    return !d[TW-1] && d != 0;
  endfunction

  task automatic step(input bit iv, input int id, input int ad, input int dly,
                      input bit rr, input bit refu, input int pc, input bit we,
                      input bit dr);
    bit exp_v, pop, acc, lastout, n_retry, n_drn;
    logic [TW-1:0] lag, nrt;
    int k;
    @(negedge clk);
    nrt = now + TW'(dly);
    ins_valid = iv; ins_id = IW'(id); ins_addr = AW'(ad); ins_due = nrt;
    rsp_ready = rr; rd_refused = refu; pend_cnt = PW'(pc);
    wr_empty = we; drain_req = dr;
    #1;
    lag = now - m_rt[0];
    exp_v = (m_n > 0) && !lag[TW-1];
    chk("R5 count", int'(count), m_n);
    chk("R6 rd_full", int'(rd_full), int'(pc + m_n >= RD_BUF));
    chk("R2 rsp_valid", int'(rsp_valid), int'(exp_v));
    if (exp_v) begin
      chk("R1 rsp_id order", int'(rsp_id), m_id[0]);
      chk("R2 rsp_addr", int'(rsp_addr), m_ad[0]);
    end
    chk("R7 retry_pulse", int'(retry_pulse), int'(e_retry));
    chk("R8 drained", int'(drained), int'(e_drained));
    pop = exp_v && rr;
    acc = iv && (m_n < DEPTH || pop);
    lastout = pop && m_n == 1 && !acc;
    n_retry = m_flag && pop;
    m_flag = refu || (m_flag && !pop);
    n_drn = lastout && pc == 0 && we && dr;
    if (pop) begin
      for (int j = 0; j < DEPTH; j++) begin
        m_id[j] = m_id[j+1]; m_ad[j] = m_ad[j+1]; m_rt[j] = m_rt[j+1];
      end
      m_n--;
    end
    if (acc) begin
      k = m_n;
      for (int j = m_n - 1; j >= 0; j--) if (later(m_rt[j], nrt)) k = j;
      for (int j = m_n; j > k; j--) begin
        m_id[j] = m_id[j-1]; m_ad[j] = m_ad[j-1]; m_rt[j] = m_rt[j-1];
      end
      m_id[k] = id & 15; m_ad[k] = ad & 255; m_rt[k] = nrt;
      m_n++;
    end
    @(posedge clk);
    #1;
    now = now + 1'b1;
    e_retry = n_retry;
    e_drained = n_drn;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; now = '0;
    ins_valid = 0; ins_id = '0; ins_addr = '0; ins_due = '0;
    rsp_ready = 0; rd_refused = 0; pend_cnt = '0; wr_empty = 1; drain_req = 0;
    m_n = 0; m_flag = 0; e_retry = 0; e_drained = 0;
    for (int j = 0; j <= DEPTH; j++) begin m_id[j] = 0; m_ad[j] = 0; m_rt[j] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R5 reset state
    chk("R5 reset count", int'(count), 0);
    chk("R5 reset rsp_valid", int'(rsp_valid), 0);
    chk("R5 reset retry_pulse", int'(retry_pulse), 0);
    chk("R5 reset drained", int'(drained), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 ties keep arrival order: expected leave order 2,4,1,3
    step(1, 1, 8'h11, 5, 0, 0, 0, 1, 0);
    step(1, 2, 8'h22, 2, 0, 1, 0, 1, 0);
    step(1, 3, 8'h33, 3, 0, 0, 0, 1, 0);
    step(1, 4, 8'h44, 0, 0, 0, 0, 1, 0);
    // R4 full queue ignores insert
    step(1, 5, 8'h55, 0, 0, 0, 1, 1, 0);
    chk("R4 full insert ignored", int'(count), 4);
    // R7 R8 drain out with retry flag set
    repeat (10) step(0, 0, 0, 0, 1, 0, 0, 1, 1);
    chk("R8 queue emptied", int'(count), 0);

    // near-exhaustive pseudo-random sweep over positions and timing
    for (int c = 0; c < 6000; c++) begin
      step(rnd(3) != 0, rnd(16), rnd(256), rnd(6), rnd(10) < 6, rnd(8) == 0,
           rnd(4), rnd(2) == 0, rnd(2) == 0);
    end
    // R3 R8 final drain
    repeat (12) step(0, 0, 0, 0, 1, 0, 0, 1, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule